// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of an event timer. A free-running main counter is supplied from outside on `cnt_i`. The channel holds a comparator and a period register. When the counter reaches the comparator, the channel emits a one-cycle interrupt pulse. The channel has three ways of working. In one-shot mode it fires once and then goes idle. In periodic mode it moves the comparator forward by the period after each match, stepping again until the comparator is ahead of the counter. In 32-bit mode all ordering tests use only the low half of the counter, and a one-shot channel also fires when the low half of the counter wraps.

Software reaches the channel through a 32-bit word port with four word addresses. These hold the configuration, a read-only routing-capability word, and the low and high comparator halves. A configuration bit redirects comparator-half writes, so that a periodic channel can have both its comparator and its period loaded. The route field is driven out so that the interrupt can be steered elsewhere.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset, word 0 reads 0x00030000, word 1 reads 0x00000004, words 2 and 3 read 0xFFFFFFFF, the period is zero, and `irq_o` and `route_o` are 0.
- R2: Word 0 is the configuration word. Bit 0 is the channel enable, bit 1 selects periodic mode, bit 2 is the direct-load bit, bit 3 selects 32-bit mode, bit 4 is a level request that behaves as edge, and bits 12:8 hold the route. Bits 16 and 17 are read-only capability bits (periodic, 64-bit) that read as 1. All other bits read 0, and writing 0xFFFFFFFF reads back 0x00031F1F. Writes to word 1 are ignored, and word 1 always reads 0x00000004.
- R3: In one-shot mode, a counter at or past the comparator (signed difference) gives exactly one `irq_o` pulse, one cycle wide, and the channel then stays idle until it is armed again.
- R4: A pulse is emitted only while both the channel enable (word 0 bit 0) and `glb_en_i` are 1.
- R5: In periodic mode with a nonzero period, each match adds the period to the comparator, one addition per cycle, until the comparator is strictly ahead of the counter. Only one pulse is emitted per match.
- R6: A write to word 2 or 3 loads the comparator only in one-shot mode or while the direct-load bit is set. In periodic mode, a write to word 2 loads the low period half, and with the direct-load bit set it loads the comparator as well. A write to word 3 in periodic mode without the direct-load bit loads the high period half.
- R7: Any write to word 2 or 3 clears the direct-load bit.
- R8: A value written into the period has its top bit cleared: bit 31 of a word-2 write in 32-bit mode, or bit 31 of a word-3 write in 64-bit mode.
- R9: Writing word 0 with bit 3 set clears the upper halves of the comparator and the period. While in 32-bit mode, writes to word 3 are ignored.
- R10: When a one-shot channel in 32-bit mode is armed and the low counter half would pass 0xFFFFFFFF before reaching the comparator, the channel fires once when the low half reaches 0xFFFFFFFF. It then fires again at the comparator match.
- R11: Dropping `glb_en_i` disarms the channel. A rising `glb_en_i` re-arms it only when the comparator is not all ones. A comparator write while `glb_en_i` is 1 also re-arms it.
- R12: `route_o` always equals configuration bits 12:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Main counter value |
| glb_en_i | input | 1 | Global enable of counter and interrupts |
| wr_i | input | 1 | Word write strobe |
| addr_i | input | 2 | Word address (0 config, 1 capability, 2 comparator low, 3 comparator high) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| route_o | output | 5 | Interrupt route selection |

## Verification
The tests exercise the matching logic in several ways.

- **Counter steps:** the counter is moved in single steps up to the comparator, which separates a match at equality from a premature one.
- **Counter jumps:** the counter also jumps far past the comparator. In periodic mode this checks that repeated catch-up additions produce a single pulse and the right final comparator.
- **Low-half wrap:** in 32-bit one-shot mode, a counter placed just below the low-half wrap is set against a counter placed well before the comparator. This separates the extra wrap pulse from a plain match.
- **Enable gating:** toggling the global enable and the channel enable, with the counter already past the comparator, separates disarming from pulse gating.
- **Direct-load and masking:** an all-ones comparator probes the re-arm rule. A period written with its top bit set shows the masking through the advanced comparator value.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int TMR_DW      = 32;
    localparam int TMR_ROUTE_W = 5;

    // configuration word bit positions
    localparam int CB_EN      = 0;
    localparam int CB_PERIOD  = 1;
    localparam int CB_DLOAD   = 2;
    localparam int CB_NARROW  = 3;
    localparam int CB_LEVEL   = 4;
    localparam int CB_ROUTE   = 8;
    localparam int CB_CAP_PER = 16;
    localparam int CB_CAP_WID = 17;

    typedef enum logic [1:0] {
        WA_CFG     = 2'd0,
        WA_CAP     = 2'd1,
        WA_CMP_LO  = 2'd2,
        WA_CMP_HI  = 2'd3
    } tmr_word_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ARMED = 2'd2,
        ST_ADV   = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic [TMR_ROUTE_W-1:0] route;
        logic                   level;
        logic                   narrow;
        logic                   dload;
        logic                   periodic;
        logic                   en;
    } tmr_cfg_t;

    function automatic logic [TMR_DW-1:0] cfg_encode(tmr_cfg_t c, logic per_cap, logic wide_cap);
        logic [TMR_DW-1:0] w;
        w = '0;
        w[CB_EN]      = c.en;
        w[CB_PERIOD]  = c.periodic;
        w[CB_DLOAD]   = c.dload;
        w[CB_NARROW]  = c.narrow;
        w[CB_LEVEL]   = c.level;
        w[CB_ROUTE +: TMR_ROUTE_W] = c.route;
        w[CB_CAP_PER] = per_cap;
        w[CB_CAP_WID] = wide_cap;
        return w;
    endfunction

    function automatic tmr_cfg_t cfg_decode(logic [TMR_DW-1:0] w, logic per_cap, logic wide_cap);
        tmr_cfg_t c;
        c.en       = w[CB_EN];
        c.periodic = w[CB_PERIOD] & per_cap;
        c.dload    = w[CB_DLOAD];
        c.narrow   = w[CB_NARROW] | ~wide_cap;
        c.level    = w[CB_LEVEL];
        c.route    = w[CB_ROUTE +: TMR_ROUTE_W];
        return c;
    endfunction

endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
    import evt_tmr_pkg::*;
#(
    parameter int          CNT_W     = 64,
    parameter bit          PER_CAP   = 1'b1,
    parameter bit          WIDE_CAP  = 1'b1,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [TMR_DW-1:0] wdata_i,
    output logic [TMR_DW-1:0] rdata_o,
    input  logic              adv_i,
    input  logic [CNT_W-1:0]  adv_val_i,
    output tmr_cfg_t          cfg_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              cmp_wr_o
);
    localparam int HALF = CNT_W / 2;

    tmr_cfg_t           cfg_q;
    tmr_cfg_t           cfg_in;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   period_q;
    logic [HALF-1:0]    per_mask_lo;
    logic [HALF-1:0]    per_mask_hi;
    logic               to_cmp;
    tmr_word_e          word;

    assign word        = tmr_word_e'(addr_i);
    assign cfg_in      = cfg_decode(wdata_i, PER_CAP, WIDE_CAP);
    assign to_cmp      = ~cfg_q.periodic | cfg_q.dload;
    assign per_mask_hi = {1'b0, {(HALF-1){1'b1}}};
    assign per_mask_lo = cfg_q.narrow ? per_mask_hi : '1;
    assign cmp_wr_o    = wr_i & ((word == WA_CMP_LO) | (word == WA_CMP_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            cmp_q    <= '1;
            period_q <= '0;
        end else begin
            if (adv_i) begin
                cmp_q <= adv_val_i;
            end
            if (wr_i) begin
                unique case (word)
                    WA_CFG: begin
                        cfg_q <= cfg_in;
                        if (cfg_in.narrow) begin
                            cmp_q[CNT_W-1:HALF]    <= '0;
                            period_q[CNT_W-1:HALF] <= '0;
                        end
                    end
                    WA_CAP: begin
                    end
                    WA_CMP_LO: begin
                        if (to_cmp) begin
                            cmp_q[HALF-1:0] <= wdata_i;
                        end
                        if (cfg_q.periodic) begin
                            period_q[HALF-1:0] <= wdata_i & per_mask_lo;
                        end
                        cfg_q.dload <= 1'b0;
                    end
                    WA_CMP_HI: begin
                        if (!cfg_q.narrow) begin
                            if (to_cmp) begin
                                cmp_q[CNT_W-1:HALF] <= wdata_i;
                            end else begin
                                period_q[CNT_W-1:HALF] <= wdata_i & per_mask_hi;
                            end
                        end
                        cfg_q.dload <= 1'b0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        unique case (word)
            WA_CFG:    rdata_o = cfg_encode(cfg_q, PER_CAP, WIDE_CAP);
            WA_CAP:    rdata_o = ROUTE_CAP;
            WA_CMP_LO: rdata_o = cmp_q[HALF-1:0];
            WA_CMP_HI: rdata_o = cmp_q[CNT_W-1:HALF];
        endcase
    end

    assign cfg_o    = cfg_q;
    assign cmp_o    = cmp_q;
    assign period_o = period_q;

endmodule

// File: rtl/evt_tmr_cmp.sv
module evt_tmr_cmp #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             narrow_i,
    input  logic             wrap_pend_i,
    output logic             reached_o,
    output logic [CNT_W-1:0] sum_o,
    output logic             sum_ahead_o,
    output logic             wrap_need_o
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] full_sum;
    logic [1:0]       reach_l;
    logic [1:0]       ahead_l;
    logic [HALF-1:0]  d_lo;
    logic [HALF-1:0]  d_clamp;

    // while a wrap pulse is pending the target is the top of the low half
    assign tgt      = wrap_pend_i ? {{HALF{1'b0}}, {HALF{1'b1}}} : cmp_i;
    assign full_sum = cmp_i + period_i;
    assign sum_o    = narrow_i ? {{HALF{1'b0}}, full_sum[HALF-1:0]} : full_sum;

    // lane 0 orders in the narrow width, lane 1 in the full width
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 0) ? HALF : CNT_W;
        logic [LW-1:0] d_tgt;
        logic [LW-1:0] d_sum;
        assign d_tgt      = tgt[LW-1:0] - cnt_i[LW-1:0];
        assign d_sum      = sum_o[LW-1:0] - cnt_i[LW-1:0];
        assign reach_l[g] = d_tgt[LW-1] | ~(|d_tgt);
        assign ahead_l[g] = ~d_sum[LW-1] & (|d_sum);
    end

    assign reached_o   = narrow_i ? reach_l[0] : reach_l[1];
    assign sum_ahead_o = narrow_i ? ahead_l[0] : ahead_l[1];

    // distance to the comparator, clamped at zero, against distance to wrap
    assign d_lo        = cmp_i[HALF-1:0] - cnt_i[HALF-1:0];
    assign d_clamp     = d_lo[HALF-1] ? '0 : d_lo;
    assign wrap_need_o = (~cnt_i[HALF-1:0]) < d_clamp;

endmodule

// File: rtl/evt_tmr_seq.sv
module evt_tmr_seq
    import evt_tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic glb_en_i,
    input  logic chan_en_i,
    input  logic periodic_i,
    input  logic narrow_i,
    input  logic period_nz_i,
    input  logic cmp_all1_i,
    input  logic cmp_wr_i,
    input  logic reached_i,
    input  logic sum_ahead_i,
    input  logic wrap_need_i,
    output logic adv_o,
    output logic wrap_pend_o,
    output logic irq_o
);
    tmr_state_e st_q, st_nxt;
    logic       wrap_q, wrap_nxt;
    logic       glb_q;
    logic       irq_q;
    logic       fire;
    logic       rise;

    assign rise = glb_en_i & ~glb_q;

    always_comb begin
        st_nxt   = st_q;
        wrap_nxt = wrap_q;
        fire     = 1'b0;
        adv_o    = 1'b0;
        if (!glb_en_i) begin
            st_nxt   = ST_IDLE;
            wrap_nxt = 1'b0;
        end else if (cmp_wr_i || (rise && !cmp_all1_i)) begin
            st_nxt   = ST_SETUP;
            wrap_nxt = 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                end
                ST_SETUP: begin
                    wrap_nxt = narrow_i & ~periodic_i & wrap_need_i;
                    st_nxt   = ST_ARMED;
                end
                ST_ARMED: begin
                    if (reached_i) begin
                        fire = 1'b1;
                        if (wrap_q) begin
                            wrap_nxt = 1'b0;
                        end else if (periodic_i && period_nz_i) begin
                            st_nxt = ST_ADV;
                        end else begin
                            st_nxt = ST_IDLE;
                        end
                    end
                end
                ST_ADV: begin
                    adv_o = 1'b1;
                    if (sum_ahead_i) begin
                        st_nxt = ST_ARMED;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            wrap_q <= 1'b0;
            glb_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            wrap_q <= wrap_nxt;
            glb_q  <= glb_en_i;
            irq_q  <= fire & chan_en_i & glb_en_i;
        end
    end

    assign wrap_pend_o = wrap_q;
    assign irq_o       = irq_q;

endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
    import evt_tmr_pkg::*;
#(
    parameter int          CNT_W     = 64,
    parameter bit          PER_CAP   = 1'b1,
    parameter bit          WIDE_CAP  = 1'b1,
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0004
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic                   glb_en_i,
    input  logic                   wr_i,
    input  logic [1:0]             addr_i,
    input  logic [TMR_DW-1:0]      wdata_i,
    output logic [TMR_DW-1:0]      rdata_o,
    output logic                   irq_o,
    output logic [TMR_ROUTE_W-1:0] route_o
);
    tmr_cfg_t         cfg;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] sum;
    logic             cmp_wr;
    logic             adv;
    logic             wrap_pend;
    logic             reached;
    logic             sum_ahead;
    logic             wrap_need;
    logic             chan_en;
    logic             narrow;
    logic             dload;

    assign chan_en = cfg.en;
    assign narrow  = cfg.narrow;
    assign dload   = cfg.dload;

    evt_tmr_regs #(
        .CNT_W     (CNT_W),
        .PER_CAP   (PER_CAP),
        .WIDE_CAP  (WIDE_CAP),
        .ROUTE_CAP (ROUTE_CAP)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .adv_i     (adv),
        .adv_val_i (sum),
        .cfg_o     (cfg),
        .cmp_o     (cmp_q),
        .period_o  (period_q),
        .cmp_wr_o  (cmp_wr)
    );

    evt_tmr_cmp #(
        .CNT_W (CNT_W)
    ) cmp_i (
        .cnt_i       (cnt_i),
        .cmp_i       (cmp_q),
        .period_i    (period_q),
        .narrow_i    (narrow),
        .wrap_pend_i (wrap_pend),
        .reached_o   (reached),
        .sum_o       (sum),
        .sum_ahead_o (sum_ahead),
        .wrap_need_o (wrap_need)
    );

    evt_tmr_seq seq_i (
        .clk         (clk),
        .rst         (rst),
        .glb_en_i    (glb_en_i),
        .chan_en_i   (chan_en),
        .periodic_i  (cfg.periodic),
        .narrow_i    (narrow),
        .period_nz_i (|period_q),
        .cmp_all1_i  (&cmp_q),
        .cmp_wr_i    (cmp_wr),
        .reached_i   (reached),
        .sum_ahead_i (sum_ahead),
        .wrap_need_i (wrap_need),
        .adv_o       (adv),
        .wrap_pend_o (wrap_pend),
        .irq_o       (irq_o)
    );

    assign route_o = cfg.route;

endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             glb_en_i,
    input logic             chan_en,
    input logic             irq_o,
    input logic             narrow,
    input logic             dload,
    input logic             cmp_wr,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] period_q
);
    localparam int HALF = CNT_W / 2;

    // R3
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R4
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !$past(rst)) |-> ($past(glb_en_i) && $past(chan_en)));

    // R7
    dload_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmp_wr)) |-> !dload);

    // R8
    period_top_chk: assert property (@(posedge clk) disable iff (rst)
        !period_q[CNT_W-1]);

    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        narrow |-> (cmp_q[CNT_W-1:HALF] == '0 && period_q[CNT_W-1:HALF] == '0));

endmodule

bind evt_timer_channel evt_tmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .glb_en_i (glb_en_i),
    .chan_en  (chan_en),
    .irq_o    (irq_o),
    .narrow   (narrow),
    .dload    (dload),
    .cmp_wr   (cmp_wr),
    .cmp_q    (cmp_q),
    .period_q (period_q)
);

// File: tb/evt_timer_channel_tb_top.sv
module evt_timer_channel_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = '0;
    logic        glb_en = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [4:0]  route;

    int checks = 0;
    int bad = 0;
    int pulses = 0;
    int base = 0;
    bit done = 1'b0;

    evt_timer_channel dut_i (
        .clk      (clk),
        .rst      (rst),
        .cnt_i    (cnt),
        .glb_en_i (glb_en),
        .wr_i     (wr),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_o    (irq),
        .route_o  (route)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (irq) pulses++;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_cnt(logic [63:0] v);
        @(negedge clk);
        cnt = v;
        idle(6);
    endtask

    task automatic set_glb(logic v);
        @(negedge clk);
        glb_en = v;
        idle(6);
    endtask

    task automatic pulse_chk(string req, int exp);
        chk(req, pulses - base, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 cfg", 2'd0, 32'h0003_0000);
        rd_chk("R1 cap", 2'd1, 32'h0000_0004);
        rd_chk("R1 cmp lo", 2'd2, 32'hFFFF_FFFF);
        rd_chk("R1 cmp hi", 2'd3, 32'hFFFF_FFFF);
        chk("R1 irq", irq, 0);
        chk("R1 route", route, 0);
    endtask

    task automatic t_oneshot;
        set_glb(0);
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd2, 32'd110);
        set_cnt(64'd100);
        base = pulses;
        set_glb(1);
        pulse_chk("R3 before match", 0);
        set_cnt(64'd109);
        pulse_chk("R3 one short", 0);
        set_cnt(64'd110);
        pulse_chk("R3 at match", 1);
        set_cnt(64'd130);
        pulse_chk("R3 no repeat", 1);
    endtask

    task automatic t_gate;
        set_glb(0);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd2, 32'd300);
        set_cnt(64'd290);
        base = pulses;
        set_glb(1);
        set_cnt(64'd310);
        pulse_chk("R4 channel disabled", 0);
    endtask

    task automatic t_periodic;
        set_glb(0);
        wr_reg(2'd0, 32'h7);
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd0, 32'h7);
        wr_reg(2'd2, 32'd200);
        wr_reg(2'd2, 32'd50);
        rd_chk("R7 dload cleared", 2'd0, 32'h0003_0003);
        rd_chk("R6 cmp kept", 2'd2, 32'd200);
        set_cnt(64'd150);
        base = pulses;
        set_glb(1);
        pulse_chk("R5 armed", 0);
        set_cnt(64'd200);
        pulse_chk("R5 first", 1);
        rd_chk("R5 advanced", 2'd2, 32'd250);
        set_cnt(64'd250);
        pulse_chk("R5 second", 2);
        set_cnt(64'd420);
        idle(6);
        pulse_chk("R5 catch-up single", 3);
        rd_chk("R5 catch-up cmp", 2'd2, 32'd450);
    endtask

    task automatic t_msb;
        set_glb(0);
        wr_reg(2'd0, 32'hF);
        wr_reg(2'd2, 32'h10);
        wr_reg(2'd2, 32'hFFFF_FFF0);
        set_cnt(64'd5);
        base = pulses;
        set_glb(1);
        set_cnt(64'h10);
        pulse_chk("R8 fire", 1);
        rd_chk("R8 masked period", 2'd2, 32'h8000_0000);
    endtask

    task automatic t_narrow;
        set_glb(0);
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd3, 32'h5);
        wr_reg(2'd2, 32'h10);
        rd_chk("R9 wide hi", 2'd3, 32'h5);
        wr_reg(2'd0, 32'h9);
        rd_chk("R9 truncated", 2'd3, 32'h0);
        wr_reg(2'd3, 32'h7);
        rd_chk("R9 hi ignored", 2'd3, 32'h0);
        rd_chk("R9 cfg", 2'd0, 32'h0003_0009);
    endtask

    task automatic t_wrap;
        set_glb(0);
        wr_reg(2'd2, 32'h20);
        set_cnt(64'h1_FFFF_FF00);
        base = pulses;
        set_glb(1);
        set_cnt(64'h1_FFFF_FFFE);
        pulse_chk("R10 before wrap", 0);
        set_cnt(64'h1_FFFF_FFFF);
        pulse_chk("R10 wrap pulse", 1);
        set_cnt(64'h2_0000_0010);
        pulse_chk("R10 between", 1);
        set_cnt(64'h2_0000_0020);
        pulse_chk("R10 match after wrap", 2);
        set_glb(0);
        set_cnt(64'h2_0000_0010);
        wr_reg(2'd2, 32'h40);
        base = pulses;
        set_glb(1);
        set_cnt(64'h2_FFFF_FFFF);
        pulse_chk("R10 no wrap pulse", 0);
        set_cnt(64'h3_0000_0040);
        pulse_chk("R10 plain match", 1);
    endtask

    task automatic t_glb;
        set_glb(0);
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd3, 32'h0);
        wr_reg(2'd2, 32'd500);
        set_cnt(64'd400);
        base = pulses;
        set_glb(1);
        pulse_chk("R11 armed early", 0);
        set_glb(0);
        set_cnt(64'd600);
        pulse_chk("R11 disarmed", 0);
        set_glb(1);
        pulse_chk("R11 rearm fires", 1);
        set_glb(0);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        base = pulses;
        set_glb(1);
        pulse_chk("R11 all ones not armed", 0);
    endtask

    task automatic t_mask;
        set_glb(0);
        wr_reg(2'd0, 32'hFFFF_FFFF);
        rd_chk("R2 mask", 2'd0, 32'h0003_1F1F);
        chk("R12 route all", route, 5'h1F);
        wr_reg(2'd1, 32'h0);
        rd_chk("R2 cap word", 2'd1, 32'h0000_0004);
        wr_reg(2'd0, 32'h0000_1300);
        rd_chk("R2 cfg", 2'd0, 32'h0003_1300);
        chk("R12 route", route, 5'h13);
    endtask

    initial begin
        idle(4);
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        t_reset;
        t_oneshot;
        t_gate;
        t_periodic;
        t_msb;
        t_narrow;
        t_wrap;
        t_glb;
        t_mask;
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule